// File: doc/BRIEF.md
# Memory-Mapped I/O Register Access Unit

This block sits beside the core of a small 8-bit controller. It holds the I/O registers that the core reaches through four kinds of request. The first is a port-style access on a short I/O address. The second is a load or store on a full 8-bit data address. The third is a single-bit set or clear. The fourth is a single-bit test. The block decodes each request to one target register and applies a per-bit write mask. It returns read data and the tested bit combinationally from the current register state.

The same register answers at two addresses. In the data view it sits 0x20 above its I/O address. The block holds four general-purpose storage registers, a status register whose flags peripherals set and software clears by writing ones, and a control register with reserved bits. Above the port-reachable window there is a small bank of extended registers that only loads and stores can reach. Requests outside their legal window raise a strobe and change nothing.

Default map, by I/O address. The status flags are at 0x16 (data 0x36), with flags in bits 3:0. The general-purpose registers are at 0x1C to 0x1F (data 0x3C to 0x3F). The control register is at 0x30 (data 0x50), and only bits 3:0 are writable. The extended registers are at data 0x60 to 0x63.

Top module: `mmio_access_unit`

## Requirements
- R1: After reset every register reads 0x00 and no illegal strobe is raised while the bus is idle.
- R2: A port request (kind 0) with I/O address 0x00 to 0x3F reads the addressed register or, when write is high, stores the write byte into it.
- R3: A data request (kind 1) at address A reaches the same register as a port request at A minus 0x20. A write made through one view reads back through the other.
- R4: Extended registers at data 0x60 and up answer only to data requests. A port request with an address above 0x3F raises illegal_access, reads 0x00 and writes nothing.
- R5: A bit operation (kind 2) on a general-purpose register forces only bit req_bit to req_bit_val (1 sets the bit, 0 clears it). The other seven bits keep their values.
- R6: Bit operations and bit tests (kinds 2 and 3) are legal only for I/O addresses 0x00 to 0x1F. Outside that window they raise illegal_access, return 0 and modify no register.
- R7: A bit test (kind 3) drives bit_value with bit req_bit of the addressed register and modifies nothing.
- R8: A byte write to the status register clears each flag whose write bit is 1 and leaves every flag whose write bit is 0 unchanged.
- R9: A bit operation with value 1 on the status register clears only the named flag. With value 0 it has no effect.
- R10: A peripheral set pulse on flag_set[i] leaves flag i at 1 after the edge, even when a clear of that flag lands in the same cycle.
- R11: Writes to unmapped addresses are ignored and reads of them return 0x00. Reserved bits of the status and control registers always read 0.
- R12: Read data reflects the register state before the edge. A write becomes visible from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 port, 1 data, 2 bit operation, 3 bit test |
| req_write | input | 1 | Write for kinds 0 and 1 (ignored for 2 and 3) |
| req_addr | input | 8 | I/O address (kinds 0, 2, 3) or data address (kind 1) |
| req_bit | input | 3 | Bit index for kinds 2 and 3 |
| req_bit_val | input | 1 | Value written by a bit operation |
| req_wdata | input | 8 | Byte written by port or data writes |
| flag_set | input | 4 | Peripheral pulses that set status flags |
| rdata | output | 8 | Combinational read byte for kinds 0 and 1 |
| bit_value | output | 1 | Combinational tested bit for kind 3 |
| illegal_access | output | 1 | Request lies outside its legal address window |

## Verification
Three kinds of result are due at different times. rdata, bit_value and illegal_access settle in the same cycle as the request, so the bench samples them one nanosecond after it drives the inputs on the falling edge. Register updates land on the next rising edge and are observed through a read issued at the following falling edge. The bench never samples a write's effect in the cycle that produced it. The one exception is the R12 check, which deliberately reads the old value there. Peripheral set pulses follow the same one-edge rule.

// File: rtl/mmio_pkg.sv
`timescale 1ns/1ps
// Package: shared request kinds, decode targets and address-window limits
// for the memory-mapped I/O access unit. Assumes an 8-bit data path.
package mmio_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;     // register index width inside a bank (max 16 per bank)

    // Address windows that are part of the access rules
    localparam logic [7:0] IO_PORT_LAST = 8'h3F;   // last address for port requests
    localparam logic [7:0] IO_BIT_LAST  = 8'h1F;   // last address for bit requests
    localparam logic [8:0] VIEW_OFFSET  = 9'h020;  // data view = I/O view + offset

    typedef enum logic [1:0] {
        KIND_PORT    = 2'd0,
        KIND_DATA    = 2'd1,
        KIND_BITOP   = 2'd2,
        KIND_BITTEST = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_GP   = 3'd1,
        TGT_EXT  = 3'd2,
        TGT_FLAG = 3'd3,
        TGT_CTRL = 3'd4
    } tgt_e;

endpackage

// File: rtl/mmio_addr_decode.sv
`timescale 1ns/1ps
// Module: mmio_addr_decode
// Translates a request into one target register, a write enable and a
// per-bit write mask. Port and bit requests are moved into the data view by
// adding the fixed offset, so one comparator set serves all request kinds.
// Assumes: req_* inputs are stable for the whole cycle; purely combinational
// apart from the assertions, which use clk and rst_n.
module mmio_addr_decode
    import mmio_pkg::*;
#(
    parameter int         GP_COUNT      = 4,
    parameter logic [7:0] GP_IO_BASE    = 8'h1C,
    parameter logic [7:0] FLAG_IO_ADDR  = 8'h16,
    parameter logic [7:0] CTRL_IO_ADDR  = 8'h30,
    parameter int         EXT_COUNT     = 4,
    parameter logic [7:0] EXT_DATA_BASE = 8'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_write,
    input  logic [7:0]       req_addr,
    input  logic [2:0]       req_bit,
    input  logic             req_bit_val,
    input  logic [7:0]       req_wdata,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] tgt_idx,
    output logic             illegal,
    output logic             wr_en,
    output logic             is_bitop,
    output logic [7:0]       wr_mask,
    output logic [7:0]       wr_data
);

    localparam logic [8:0] GP_DBASE   = {1'b0, GP_IO_BASE} + VIEW_OFFSET;
    localparam logic [8:0] GP_DEND    = GP_DBASE + 9'(GP_COUNT);
    localparam logic [8:0] FLAG_DADDR = {1'b0, FLAG_IO_ADDR} + VIEW_OFFSET;
    localparam logic [8:0] CTRL_DADDR = {1'b0, CTRL_IO_ADDR} + VIEW_OFFSET;
    localparam logic [8:0] EXT_DBASE  = {1'b0, EXT_DATA_BASE};
    localparam logic [8:0] EXT_DEND   = EXT_DBASE + 9'(EXT_COUNT);

    req_kind_e  kind;
    logic       range_ok;
    logic [8:0] daddr;

    assign kind = req_kind_e'(req_kind);

    // Range check: each request kind has its own legal address window
    always_comb begin
        case (kind)
            KIND_PORT: range_ok = (req_addr <= IO_PORT_LAST);
            KIND_DATA: range_ok = 1'b1;
            default:   range_ok = (req_addr <= IO_BIT_LAST);
        endcase
    end

    // View translation: everything except data requests is shifted into the data view
    always_comb begin
        if (kind == KIND_DATA) daddr = {1'b0, req_addr};
        else                   daddr = {1'b0, req_addr} + VIEW_OFFSET;
    end

    // Target match: compares the data-view address against each register window
    always_comb begin
        tgt     = TGT_NONE;
        tgt_idx = '0;
        if (req_valid && range_ok) begin
            if (daddr >= GP_DBASE && daddr < GP_DEND) begin
                tgt     = TGT_GP;
                tgt_idx = IDX_W'(daddr - GP_DBASE);
            end else if (daddr == FLAG_DADDR) begin
                tgt = TGT_FLAG;
            end else if (daddr == CTRL_DADDR) begin
                tgt = TGT_CTRL;
            end else if (daddr >= EXT_DBASE && daddr < EXT_DEND) begin
                tgt     = TGT_EXT;
                tgt_idx = IDX_W'(daddr - EXT_DBASE);
            end
        end
    end

    // Write control: byte writes carry the full byte, bit operations a one-hot mask
    always_comb begin
        is_bitop = (kind == KIND_BITOP);
        illegal  = req_valid && !range_ok;
        wr_en    = 1'b0;
        wr_mask  = 8'hFF;
        wr_data  = req_wdata;
        if (req_valid && range_ok) begin
            case (kind)
                KIND_PORT, KIND_DATA: wr_en = req_write;
                KIND_BITOP:           wr_en = 1'b1;
                default:              wr_en = 1'b0;
            endcase
        end
        if (is_bitop) begin
            wr_mask = 8'h01 << req_bit;
            wr_data = req_bit_val ? wr_mask : 8'h00;
        end
    end

    // Bit requests above the bit-accessible window must be flagged
    p_bit_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1] && (req_addr > 8'h1F)) |-> (illegal && !wr_en && tgt == TGT_NONE))
        else $error("bit request outside window accepted");

    // Port requests above the port window must be flagged and never reach extended registers
    p_port_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0 && (req_addr > 8'h3F)) |-> (illegal && !wr_en && tgt == TGT_NONE))
        else $error("port request outside window accepted");

endmodule

// File: rtl/mmio_reg_bank.sv
`timescale 1ns/1ps
// Module: mmio_reg_bank
// A bank of COUNT plain 8-bit storage registers with a masked write port.
// Only bits set in both wr_mask and WMASK change; bits outside WMASK stay 0.
// Assumes: wr_idx is below COUNT whenever wr_en is high.
module mmio_reg_bank
    import mmio_pkg::*;
#(
    parameter int         COUNT = 4,
    parameter logic [7:0] WMASK = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_mask,
    input  logic [7:0]         wr_data,
    input  logic               is_bitop,
    output logic [COUNT*8-1:0] q
);

    for (genvar g = 0; g < COUNT; g++) begin : g_reg
        logic [7:0] r;
        logic       hit;
        logic [7:0] m;

        assign hit = wr_en && (wr_idx == IDX_W'(g));
        assign m   = wr_mask & WMASK;

        // Register g: merge masked write bits, keep all others
        always_ff @(posedge clk) begin
            if (!rst_n)   r <= 8'h00;
            else if (hit) r <= (r & ~m) | (wr_data & m);
        end

        assign q[g*8 +: 8] = r;

        // A bit operation alters at most one bit of the addressed register
        p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && is_bitop && wr_idx == IDX_W'(g)) |=> ($countones(q[g*8 +: 8] ^ $past(q[g*8 +: 8])) <= 1))
            else $error("bit operation changed more than one bit");

        // A write aimed elsewhere leaves this register untouched
        p_other_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_idx != IDX_W'(g)) |=> $stable(q[g*8 +: 8]))
            else $error("register changed without being addressed");
    end

endmodule

// File: rtl/mmio_flag_reg.sv
`timescale 1ns/1ps
// Module: mmio_flag_reg
// Status flags that peripherals set and software clears by writing ones.
// A set pulse beats a clear of the same flag in the same cycle.
// Assumes: wr_mask/wr_data come from the decoder (full byte or one-hot bit).
module mmio_flag_reg #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_mask,
    input  logic [7:0]        wr_data,
    input  logic [FLAG_W-1:0] flag_set,
    output logic [FLAG_W-1:0] q
);

    logic [FLAG_W-1:0] clr;

    // Clear vector: ones written under the mask, only while a write is active
    assign clr = wr_en ? FLAG_W'(wr_mask & wr_data) : '0;

    // Flag update: clear first, then OR in peripheral sets so sets win
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | flag_set;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((q & $past(flag_set)) == $past(flag_set)))
        else $error("peripheral set lost");

    p_no_spurious_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set == '0) |=> ((q & ~$past(q)) == '0))
        else $error("flag rose without a set pulse");

    p_zero_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (FLAG_W'(wr_mask & wr_data) == '0)) |=> ((q & $past(q)) == $past(q)))
        else $error("flag cleared without a one written");

endmodule

// File: rtl/mmio_access_unit.sv
`timescale 1ns/1ps
// Module: mmio_access_unit (top)
// I/O register file and access decoder. Routes port, data, bit-operation and
// bit-test requests to the general-purpose bank, the extended bank, the
// status flags or the control register. Reads are combinational; writes land
// on the rising clock edge. Assumes one request per cycle from the core.
module mmio_access_unit
    import mmio_pkg::*;
#(
    parameter int         GP_COUNT      = 4,
    parameter logic [7:0] GP_IO_BASE    = 8'h1C,
    parameter logic [7:0] FLAG_IO_ADDR  = 8'h16,
    parameter int         FLAG_W        = 4,
    parameter logic [7:0] CTRL_IO_ADDR  = 8'h30,
    parameter logic [7:0] CTRL_WMASK    = 8'h0F,
    parameter int         EXT_COUNT     = 4,
    parameter logic [7:0] EXT_DATA_BASE = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [2:0]        req_bit,
    input  logic              req_bit_val,
    input  logic [7:0]        req_wdata,
    input  logic [FLAG_W-1:0] flag_set,
    output logic [7:0]        rdata,
    output logic              bit_value,
    output logic              illegal_access
);

    tgt_e                  tgt;
    logic [IDX_W-1:0]      tgt_idx;
    logic                  dec_wr;
    logic                  dec_bitop;
    logic [7:0]            dec_mask;
    logic [7:0]            dec_data;
    logic [GP_COUNT*8-1:0] gp_q;
    logic [EXT_COUNT*8-1:0] ext_q;
    logic [7:0]            ctrl_q;
    logic [FLAG_W-1:0]     flag_q;
    logic [7:0]            sel_byte;
    logic                  legal;

    mmio_addr_decode #(
        .GP_COUNT      (GP_COUNT),
        .GP_IO_BASE    (GP_IO_BASE),
        .FLAG_IO_ADDR  (FLAG_IO_ADDR),
        .CTRL_IO_ADDR  (CTRL_IO_ADDR),
        .EXT_COUNT     (EXT_COUNT),
        .EXT_DATA_BASE (EXT_DATA_BASE)
    ) decode_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_bit     (req_bit),
        .req_bit_val (req_bit_val),
        .req_wdata   (req_wdata),
        .tgt         (tgt),
        .tgt_idx     (tgt_idx),
        .illegal     (illegal_access),
        .wr_en       (dec_wr),
        .is_bitop    (dec_bitop),
        .wr_mask     (dec_mask),
        .wr_data     (dec_data)
    );

    mmio_reg_bank #(.COUNT(GP_COUNT), .WMASK(8'hFF)) gp_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec_wr && tgt == TGT_GP),
        .wr_idx   (tgt_idx),
        .wr_mask  (dec_mask),
        .wr_data  (dec_data),
        .is_bitop (dec_bitop),
        .q        (gp_q)
    );

    mmio_reg_bank #(.COUNT(EXT_COUNT), .WMASK(8'hFF)) ext_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec_wr && tgt == TGT_EXT),
        .wr_idx   (tgt_idx),
        .wr_mask  (dec_mask),
        .wr_data  (dec_data),
        .is_bitop (dec_bitop),
        .q        (ext_q)
    );

    mmio_reg_bank #(.COUNT(1), .WMASK(CTRL_WMASK)) ctrl_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec_wr && tgt == TGT_CTRL),
        .wr_idx   ('0),
        .wr_mask  (dec_mask),
        .wr_data  (dec_data),
        .is_bitop (dec_bitop),
        .q        (ctrl_q)
    );

    mmio_flag_reg #(.FLAG_W(FLAG_W)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec_wr && tgt == TGT_FLAG),
        .wr_mask  (dec_mask),
        .wr_data  (dec_data),
        .flag_set (flag_set),
        .q        (flag_q)
    );

    // Read select: pick the current byte of the decoded target, 0 when unmapped
    always_comb begin
        sel_byte = 8'h00;
        case (tgt)
            TGT_GP: begin
                for (int i = 0; i < GP_COUNT; i++)
                    if (tgt_idx == IDX_W'(i)) sel_byte = gp_q[i*8 +: 8];
            end
            TGT_EXT: begin
                for (int i = 0; i < EXT_COUNT; i++)
                    if (tgt_idx == IDX_W'(i)) sel_byte = ext_q[i*8 +: 8];
            end
            TGT_FLAG: sel_byte = 8'(flag_q);
            TGT_CTRL: sel_byte = ctrl_q;
            default:  sel_byte = 8'h00;
        endcase
    end

    // Output steering: byte for port/data kinds, single bit for tests
    always_comb begin
        legal     = req_valid && !illegal_access;
        rdata     = (legal && !req_kind[1]) ? sel_byte : 8'h00;
        bit_value = (legal && req_kind == 2'd3) ? sel_byte[req_bit] : 1'b0;
    end

    // Illegal requests change no storage (flags may only rise through sets)
    p_illegal_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && illegal_access) |=> ($stable(gp_q) && $stable(ext_q) && $stable(ctrl_q)
                                           && ((flag_q & $past(flag_q)) == $past(flag_q))))
        else $error("illegal request modified a register");

    // A bit test is read-only
    p_test_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> ($stable(gp_q) && $stable(ext_q) && $stable(ctrl_q)
                                             && ((flag_q & $past(flag_q)) == $past(flag_q))))
        else $error("bit test modified a register");

    // Reserved control bits never become visible
    p_ctrl_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == 8'h00)
        else $error("reserved control bit set");

endmodule

// File: tb/mmio_access_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for mmio_access_unit: one task per scenario, each checking
// its own results. Inputs change on the falling edge; combinational results
// are sampled 1 ns later; written state is read back in a later cycle.
module mmio_access_unit_tb_top;

    localparam int KP = 0, KD = 1, KB = 2, KT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [2:0] req_bit = '0;
    logic       req_bit_val = 1'b0;
    logic [7:0] req_wdata = '0;
    logic [3:0] flag_set = '0;
    logic [7:0] rdata;
    logic       bit_value;
    logic       illegal_access;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] s_rd;
    logic       s_bv;
    logic       s_il;

    always #2.5 clk = ~clk;

    mmio_access_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_bit        (req_bit),
        .req_bit_val    (req_bit_val),
        .req_wdata      (req_wdata),
        .flag_set       (flag_set),
        .rdata          (rdata),
        .bit_value      (bit_value),
        .illegal_access (illegal_access)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request in one cycle; combinational outputs captured before the edge
    task automatic op(input int kind, input logic wr, input logic [7:0] addr,
                      input logic [2:0] b, input logic bv, input logic [7:0] wd,
                      input logic [3:0] fs = 4'h0);
        @(negedge clk);
        req_valid   = 1'b1;
        req_kind    = 2'(kind);
        req_write   = wr;
        req_addr    = addr;
        req_bit     = b;
        req_bit_val = bv;
        req_wdata   = wd;
        flag_set    = fs;
        #1;
        s_rd = rdata;
        s_bv = bit_value;
        s_il = illegal_access;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        flag_set  = 4'h0;
        #1;
        s_rd = rdata;
        s_bv = bit_value;
        s_il = illegal_access;
    endtask

    task automatic t_reset();
        idle();
        chk("R1 idle illegal", 8'(s_il), 8'h00);
        op(KP, 0, 8'h1C, 0, 0, 0);  chk("R1 gp0 after reset", s_rd, 8'h00);
        op(KD, 0, 8'h36, 0, 0, 0);  chk("R1 flags after reset", s_rd, 8'h00);
        op(KD, 0, 8'h60, 0, 0, 0);  chk("R1 ext0 after reset", s_rd, 8'h00);
    endtask

    task automatic t_views();
        op(KP, 1, 8'h1D, 0, 0, 8'hA5); chk("R2 port write legal", 8'(s_il), 8'h00);
        op(KP, 0, 8'h1D, 0, 0, 0);     chk("R2 port readback", s_rd, 8'hA5);
        op(KD, 0, 8'h3D, 0, 0, 0);     chk("R3 data view of port write", s_rd, 8'hA5);
        op(KD, 1, 8'h3E, 0, 0, 8'h5A);
        op(KP, 0, 8'h1E, 0, 0, 0);     chk("R3 port view of data write", s_rd, 8'h5A);
    endtask

    task automatic t_extended();
        op(KD, 1, 8'h61, 0, 0, 8'h77);
        op(KD, 0, 8'h61, 0, 0, 0);     chk("R4 ext data readback", s_rd, 8'h77);
        op(KP, 1, 8'h41, 0, 0, 8'hEE); chk("R4 port above window flagged", 8'(s_il), 8'h01);
        op(KD, 0, 8'h61, 0, 0, 0);     chk("R4 ext untouched by port", s_rd, 8'h77);
        op(KP, 0, 8'h81, 0, 0, 0);     chk("R4 port read above window", s_rd, 8'h00);
        chk("R4 port read above window flagged", 8'(s_il), 8'h01);
    endtask

    task automatic t_bitops();
        op(KP, 1, 8'h1C, 0, 0, 8'h0F);
        op(KB, 0, 8'h1C, 3'd6, 1, 8'h00); chk("R6 bit op in window legal", 8'(s_il), 8'h00);
        op(KP, 0, 8'h1C, 0, 0, 0);        chk("R5 set bit 6", s_rd, 8'h4F);
        op(KB, 0, 8'h1C, 3'd0, 0, 8'hFF);
        op(KP, 0, 8'h1C, 0, 0, 0);        chk("R5 clear bit 0", s_rd, 8'h4E);
        op(KT, 0, 8'h1C, 3'd6, 0, 0);     chk("R7 test bit 6", 8'(s_bv), 8'h01);
        op(KT, 0, 8'h1C, 3'd0, 0, 0);     chk("R7 test bit 0", 8'(s_bv), 8'h00);
        op(KP, 0, 8'h1C, 0, 0, 0);        chk("R7 test left register intact", s_rd, 8'h4E);
    endtask

    task automatic t_bit_window();
        op(KP, 1, 8'h30, 0, 0, 8'h05);
        op(KB, 0, 8'h30, 3'd7, 1, 0);     chk("R6 bit op above window flagged", 8'(s_il), 8'h01);
        op(KP, 0, 8'h30, 0, 0, 0);        chk("R6 ctrl unchanged", s_rd, 8'h05);
        op(KT, 0, 8'h20, 3'd0, 0, 0);     chk("R6 test above window flagged", 8'(s_il), 8'h01);
        chk("R6 test above window value", 8'(s_bv), 8'h00);
    endtask

    task automatic t_flags();
        op(KP, 0, 8'h00, 0, 0, 0, 4'hF);
        op(KD, 0, 8'h36, 0, 0, 0);        chk("R10 sets captured", s_rd, 8'h0F);
        op(KD, 1, 8'h36, 0, 0, 8'h05);
        op(KD, 0, 8'h36, 0, 0, 0);        chk("R8 ones clear flags", s_rd, 8'h0A);
        op(KD, 1, 8'h36, 0, 0, 8'h00);
        op(KD, 0, 8'h36, 0, 0, 0);        chk("R8 zeros keep flags", s_rd, 8'h0A);
        op(KP, 0, 8'h00, 0, 0, 0, 4'hF);
        op(KB, 0, 8'h16, 3'd1, 1, 0);
        op(KP, 0, 8'h16, 0, 0, 0);        chk("R9 bit set clears one flag", s_rd, 8'h0D);
        op(KB, 0, 8'h16, 3'd3, 0, 0);
        op(KP, 0, 8'h16, 0, 0, 0);        chk("R9 bit clear no effect", s_rd, 8'h0D);
        op(KD, 1, 8'h36, 0, 0, 8'hFF, 4'h1);
        op(KD, 0, 8'h36, 0, 0, 0);        chk("R10 set beats clear", s_rd, 8'h01);
    endtask

    task automatic t_unmapped();
        op(KP, 1, 8'h05, 0, 0, 8'hFF);
        op(KP, 0, 8'h05, 0, 0, 0);        chk("R11 unmapped reads zero", s_rd, 8'h00);
        op(KD, 0, 8'h10, 0, 0, 0);        chk("R11 unmapped data read", s_rd, 8'h00);
        op(KP, 1, 8'h30, 0, 0, 8'hFF);
        op(KD, 0, 8'h50, 0, 0, 0);        chk("R11 ctrl reserved bits zero", s_rd, 8'h0F);
        op(KD, 0, 8'h3C, 0, 0, 0);        chk("R11 gp0 untouched", s_rd, 8'h4E);
    endtask

    task automatic t_timing();
        op(KP, 1, 8'h1F, 0, 0, 8'h33);    chk("R12 old value during write", s_rd, 8'h00);
        op(KP, 0, 8'h1F, 0, 0, 0);        chk("R12 new value after edge", s_rd, 8'h33);
    endtask

    initial begin : wdog
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_views();
        t_extended();
        t_bitops();
        t_bit_window();
        t_flags();
        t_unmapped();
        t_timing();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule